// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a 32-bit digital input bus and raises one interrupt line when a chosen group of channels changes state. Only channels 4 to 19 can take part in interrupts. Two mask registers pick the polarity each channel watches: one for a rising edge or a high level, the other for a falling edge or a low level. A control register turns the unit on and selects how the channels combine. In OR mode, any watched edge on any selected channel fires. In AND mode, the unit fires only when all selected channels sit at their chosen levels at the same time.

After an AND-mode event, the unit stays blocked until a selected input changes level. This stops a condition that holds steady from firing again and again. The channels that caused an event are kept in a status register, and reading that register clears it. Software acknowledges the interrupt by writing the control register with enable cleared and then writing it again with enable set. The raw input bus goes through a two-flop synchronizer before any detection and can be read back directly.

All registers sit on a simple single-cycle 32-bit read/write bus. Read data is combinational from the address.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, the rising mask, falling mask, status and control registers all read 0, and `irq_o` is 0.
- R2: Offset 0x00 returns the input bus after the two-flop synchronizer. A change on `din_i` is visible there within three clock edges.
- R3: Writes to the rising mask (0x04) and falling mask (0x08) are ANDed with 0x000FFFF0. A read returns the stored value.
- R4: In OR mode (control bit 1 = 0), a 0-to-1 transition on a channel set in the rising mask sets that channel's status bit. It also raises `irq_o` while enable (control bit 2) is 1. The status bit appears on the third clock edge after the input change.
- R5: In OR mode, a 1-to-0 transition on a channel set in the falling mask sets its status bit. The opposite edge on that channel sets nothing.
- R6: Inputs outside bits [19:4], and channels in neither mask, never set a status bit.
- R7: In AND mode (control bit 1 = 1), an event fires only when every rising-mask channel is high and every falling-mask channel is low in the same cycle. The status then latches the union of both masks.
- R8: After an AND-mode event, no further event fires until a level change occurs on a selected channel. Changes on unselected inputs do not re-arm the unit.
- R9: Reading status (0x0C) returns the latched channel bits and clears them, and `irq_o` then falls.
- R10: Writing the control register with enable 0 clears the status and drops `irq_o`. Setting enable again does not bring back the old event.
- R11: A control read (0x10) returns enable in bit 2, the combine mode in bit 1, and a pending flag in bit 0. The pending flag is 1 while enable is set and any status bit is set.
- R12: While enable is 0, no input activity sets a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (clears status at 0x0C) |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| din_i | input | 32 | Asynchronous digital input bus |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check several properties on every cycle. An OR-mode hit always comes with a change of the synchronized sample. An AND-mode hit only comes with every selected level matched, and is never followed by a second hit in the next cycle. A disabled unit produces no hits. Status bits stay inside the interruptible range. A status read or a disabling write empties status one cycle later. Other behaviour can only be shown by the bench scenarios: the exact latency from the input pin, the masking of written values, the read-back encoding of control, the polarity choice per channel, and the full AND-mode block-and-re-arm sequence driven by real input patterns.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RISE = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_FALL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h10;

  localparam int CTL_PEND = 0;
  localparam int CTL_AND  = 1;
  localparam int CTL_EN   = 2;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] rise_msk_i,
  input  logic [W-1:0] fall_msk_i,
  input  logic         en_i,
  input  logic         and_mode_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;
  logic [W-1:0] sel, or_hit;
  logic         chg, match, and_fire;

  always_comb begin
    sel      = rise_msk_i | fall_msk_i;
    or_hit   = (smp_i & ~prev_q & rise_msk_i) | (~smp_i & prev_q & fall_msk_i);
    chg      = |((smp_i ^ prev_q) & sel);
    match    = (sel != '0) && ((smp_i & rise_msk_i) == rise_msk_i)
               && ((~smp_i & fall_msk_i) == fall_msk_i);
    and_fire = en_i && and_mode_i && armed_q && match;
    if (!en_i)           hit_o = '0;
    else if (and_mode_i) hit_o = and_fire ? sel : '0;
    else                 hit_o = or_hit;
  end

  // blocked after an AND event until a selected level moves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      prev_q <= smp_i;
      if (and_fire) armed_q <= 1'b0;
      else if (chg) armed_q <= 1'b1;
    end
  end

  AST_OR_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !and_mode_i && hit_o != '0) |-> (smp_i != prev_q)); // R4
  AST_AND_ALL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && and_mode_i && hit_o != '0) |->
      (((smp_i & rise_msk_i) == rise_msk_i) && ((~smp_i & fall_msk_i) == fall_msk_i))); // R7
  AST_AND_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && and_mode_i && hit_o != '0) |=> (!and_mode_i || hit_o == '0)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> hit_o == '0); // R12
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int          W       = 32,
  parameter logic [W-1:0] CH_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      smp_i,
  input  logic [W-1:0]      hit_i,
  output logic [W-1:0]      rise_msk_o,
  output logic [W-1:0]      fall_msk_o,
  output logic              en_o,
  output logic              and_mode_o,
  output logic              irq_o
);
  logic [W-1:0] stat_q;
  logic         pend;
  logic         wr_ctrl, rd_stat, dis_wr;

  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign rd_stat = re_i && (addr_i == OFS_STAT);
  assign dis_wr  = wr_ctrl && !wdata_i[CTL_EN];
  assign pend    = en_o && (stat_q != '0);
  assign irq_o   = pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_msk_o <= '0;
      fall_msk_o <= '0;
      en_o       <= 1'b0;
      and_mode_o <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        OFS_RISE: rise_msk_o <= wdata_i & CH_MASK;
        OFS_FALL: fall_msk_o <= wdata_i & CH_MASK;
        OFS_CTRL: begin
          en_o       <= wdata_i[CTL_EN];
          and_mode_o <= wdata_i[CTL_AND];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (dis_wr)  stat_q <= '0;
    else if (rd_stat) stat_q <= hit_i;
    else              stat_q <= stat_q | hit_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_RAW:  rdata_o = smp_i;
      OFS_RISE: rdata_o = rise_msk_o;
      OFS_FALL: rdata_o = fall_msk_o;
      OFS_STAT: rdata_o = stat_q;
      OFS_CTRL: begin
        rdata_o[CTL_EN]   = en_o;
        rdata_o[CTL_AND]  = and_mode_o;
        rdata_o[CTL_PEND] = pend;
      end
      default: rdata_o = '0;
    endcase
  end

  AST_STAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~CH_MASK) == '0); // R6
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !dis_wr && hit_i == '0) |=> stat_q == '0); // R9
  AST_DIS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr |=> (!irq_o && stat_q == '0)); // R10
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LO_CH  = 4,
  parameter int HI_CH  = 19,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     din_i,
  output logic              irq_o
);
  localparam logic [DW-1:0] CH_MASK =
    DW'((64'(1) << (HI_CH + 1)) - 64'(1)) & ~DW'((64'(1) << LO_CH) - 64'(1));

  logic [DW-1:0] smp, hit, rise_msk, fall_msk;
  logic          en, and_mode;

  cos_sync #(.W(DW), .STAGES(STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(din_i), .q_o(smp)
  );

  cos_detect #(.W(DW)) i_detect (
    .clk_i, .rst_ni, .smp_i(smp), .rise_msk_i(rise_msk), .fall_msk_i(fall_msk),
    .en_i(en), .and_mode_i(and_mode), .hit_o(hit)
  );

  cos_regs #(.W(DW), .CH_MASK(CH_MASK)) i_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o,
    .smp_i(smp), .hit_i(hit), .rise_msk_o(rise_msk), .fall_msk_o(fall_msk),
    .en_o(en), .and_mode_o(and_mode), .irq_o
  );
endmodule

// File: tb/test_cos_irq_ctrl.sv
`timescale 1ns/1ps
module test_cos_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0, re = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, din = '0, rdata;
  logic        irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cos_irq_ctrl i_cos_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .din_i(din), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a; #0.5 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic setup();
    logic [31:0] v;
    wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
    din = 0; settle(); rd(5'h0C, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(5'h04, v); chk("R1 rise", v, 0);
    rd(5'h08, v); chk("R1 fall", v, 0);
    rd(5'h0C, v); chk("R1 stat", v, 0);
    rd(5'h10, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    din = 32'hA5A5_1234; settle(); rd(5'h00, v); chk("R2 raw", v, 32'hA5A5_1234);
    din = 0; settle(); rd(5'h00, v); chk("R2 raw zero", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); chk("R3 rise", v, 32'h000F_FFF0);
    wr(5'h08, 32'h1234_567F); rd(5'h08, v); chk("R3 fall", v, 32'h0004_5670);
    setup();
  endtask

  task automatic t_or_rise();
    logic [31:0] v;
    wr(5'h04, 32'h10); wr(5'h10, 32'h4);
    @(negedge clk); din = 32'h10;
    repeat (2) @(negedge clk); chk("R4 no irq before 3rd edge", {31'b0, irq}, 0);
    @(negedge clk); chk("R4 irq", {31'b0, irq}, 1);
    rd(5'h10, v); chk("R11 ctrl pending", v, 32'h5);
    rd(5'h0C, v); chk("R4 R9 stat", v, 32'h10);
    chk("R9 irq low after read", {31'b0, irq}, 0);
    rd(5'h0C, v); chk("R9 stat cleared", v, 0);
    rd(5'h10, v); chk("R11 ctrl idle", v, 32'h4);
    setup();
  endtask

  task automatic t_or_fall();
    logic [31:0] v;
    wr(5'h08, 32'h100); wr(5'h10, 32'h4);
    din = 32'h100; settle(); rd(5'h0C, v); chk("R5 rising ignored", v, 0);
    din = 0; settle(); rd(5'h0C, v); chk("R5 falling", v, 32'h100);
    setup();
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'hFFFF_FFFF); wr(5'h10, 32'h4);
    din = 32'hFFF0_000F; settle(); din = 0; settle();
    rd(5'h0C, v); chk("R6 out of range", v, 0);
    chk("R6 irq", {31'b0, irq}, 0);
    setup();
    wr(5'h04, 32'h10); wr(5'h10, 32'h4);
    din = 32'h20; settle(); rd(5'h0C, v); chk("R6 unselected channel", v, 0);
    setup();
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(5'h04, 32'h8_0000); wr(5'h10, 32'h4);
    din = 32'h8_0000; settle(); chk("R10 irq set", {31'b0, irq}, 1);
    wr(5'h10, 0); chk("R10 irq dropped", {31'b0, irq}, 0);
    rd(5'h10, v); chk("R10 R11 ctrl", v, 0);
    wr(5'h10, 32'h4); chk("R10 irq stays low", {31'b0, irq}, 0);
    rd(5'h0C, v); chk("R10 stat cleared", v, 0);
    setup();
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(5'h04, 32'h10);
    din = 32'h10; settle(); rd(5'h0C, v); chk("R12 disabled", v, 0);
    wr(5'h10, 32'h4); settle(); rd(5'h0C, v); chk("R12 no late event", v, 0);
    setup();
  endtask

  task automatic t_and();
    logic [31:0] v;
    wr(5'h04, 32'h10); wr(5'h08, 32'h20);
    din = 32'h20; settle();
    wr(5'h10, 32'h6); rd(5'h10, v); chk("R11 ctrl and", v, 32'h6);
    din = 32'h30; settle(); rd(5'h0C, v); chk("R7 partial match", v, 0);
    din = 32'h10; settle(); rd(5'h10, v); chk("R11 and pending", v, 32'h7);
    rd(5'h0C, v); chk("R7 full match", v, 32'h30);
    settle(); rd(5'h0C, v); chk("R8 held level blocked", v, 0);
    din = 32'h50; settle(); rd(5'h0C, v); chk("R8 unselected no rearm", v, 0);
    din = 32'h40; settle(); rd(5'h0C, v); chk("R8 change no match", v, 0);
    din = 32'h50; settle(); rd(5'h0C, v); chk("R8 rearmed fire", v, 32'h30);
    setup();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_raw();
    t_mask();
    t_or_rise();
    t_or_fall();
    t_ignore();
    t_ack();
    t_disabled();
    t_and();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule